// File: doc/BRIEF.md
# Dual-Issue SIMD Pairing Checker

This block is the issue stage of an in-order SIMD integer unit with two execution pipes, U and V. Each cycle it looks at the two oldest decoded instructions at the head of an instruction queue. It decides whether both can leave together, only the older one can leave, or nothing can leave. The older instruction always goes to the U pipe. The younger one may join it in the V pipe only when neither a register hazard nor a shared-resource conflict stands in the way.

A per-register countdown records multiply results that are still in flight. An instruction that reads a pending register, or overwrites one, waits until the result is ready. Independent work keeps flowing during the multiply's trailing cycles. The pop count `consumed` is combinational, so the queue can shift in the same cycle. The issue-valid flags and the instructions handed to each pipe are registered and appear one cycle after the decision.

Top module: `simd_pair_issue`

## Requirements
- R1: When two valid independent SIMD instructions allow pairing, `consumed` is 2. In the next cycle `issue_u` and `issue_v` are both 1, `u_op` carries the older slot and `v_op` carries the younger slot.
- R2: If the older instruction writes a register (wr=1) and the younger reads it or also writes it, only the older issues (`consumed`=1). If the younger only writes a register that the older reads, both issue.
- R3: Two instructions of the shift/pack/unpack class (cls=1) never issue together. One of them paired with a plain ALU op (cls=0) does.
- R4: Two multiplies (cls=2) never issue together. A multiply paired with an ALU op does.
- R5: An instruction with the memory/integer-access flag (bit 12) set never issues in V. As the younger instruction it waits, while as the older instruction it pairs with a plain SIMD op.
- R6: An older memory/integer-access form never pairs with a younger non-SIMD instruction (cls=3).
- R7: When the younger slot is invalid, a hazard-free older instruction issues alone (`consumed`=1, `issue_v`=0). When the older slot is invalid, nothing issues.
- R8: A multiply that issues with wr=1 makes its destination pending for MUL_LAT-1 = 2 cycles. An older instruction that reads or writes that register stalls with `consumed`=0 for those two cycles and issues on the third. An independent instruction issues in the cycle right after the multiply.
- R9: A younger instruction that touches a pending multiply destination does not issue, while the older independent one does (`consumed`=1).
- R10: While reset is high, `consumed`, `issue_u` and `issue_v` are 0, and the pending-multiply state is cleared.
- R11: Instruction word layout: bit 12 is the memory/integer-access flag, bit 11 is the write flag, bits 10:9 are the class (0 ALU, 1 shift/pack/unpack, 2 multiply, 3 non-SIMD), bits 8:6 are the destination, and bits 5:3 and 2:0 are the sources. Class 3 words have no SIMD register effects and no SIMD register hazards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s0_vld | input | 1 | Oldest queue slot holds an instruction |
| s0_op | input | 13 | Oldest instruction word |
| s1_vld | input | 1 | Second slot holds an instruction |
| s1_op | input | 13 | Second instruction word |
| consumed | output | 2 | Queue entries taken this cycle (0, 1 or 2) |
| issue_u | output | 1 | U pipe receives `u_op` this cycle |
| issue_v | output | 1 | V pipe receives `v_op` this cycle |
| u_op | output | 13 | Instruction sent to U |
| v_op | output | 13 | Instruction sent to V |

## Verification
A countdown that is left set, or one that clears too early, shows up directly at `consumed`. A stuck count holds a dependent older instruction at 0 past its third cycle. An early clear lets it issue in the first or second cycle after the multiply. Either error is visible within three cycles of the multiply leaving. A wrong pairing decision changes `consumed` in the same cycle and changes `issue_v` and `v_op` one edge later, so every rule is checked on both views.

// File: rtl/simd_pair_pkg.sv
package simd_pair_pkg;
    localparam int RIDX_W = 3;
    localparam int NREG   = 1 << RIDX_W;

    typedef enum logic [1:0] {
        CLS_ALU = 2'd0,
        CLS_SHF = 2'd1,
        CLS_MUL = 2'd2,
        CLS_EXT = 2'd3
    } op_cls_e;

    typedef struct packed {
        logic              mem;
        logic              wr;
        op_cls_e           cls;
        logic [RIDX_W-1:0] dst;
        logic [RIDX_W-1:0] sa;
        logic [RIDX_W-1:0] sb;
    } op_t;

    localparam int OP_W = $bits(op_t);
endpackage

// File: rtl/simd_pair_scoreboard.sv
module simd_pair_scoreboard
    import simd_pair_pkg::*;
#(
    parameter int MUL_LAT = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                set_a,
    input  logic [RIDX_W-1:0]   idx_a,
    input  logic                set_b,
    input  logic [RIDX_W-1:0]   idx_b,
    output logic [NREG-1:0]     busy
);
    localparam int CNT_W = (MUL_LAT > 2) ? $clog2(MUL_LAT) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(MUL_LAT - 1);

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        logic [CNT_W-1:0] cnt_d, cnt_q;

        always_comb begin
            cnt_d = cnt_q;
            if (cnt_q != '0)
                cnt_d = cnt_q - 1'b1;
            if ((set_a && idx_a == RIDX_W'(r)) || (set_b && idx_b == RIDX_W'(r)))
                cnt_d = LOAD;
        end

        always_ff @(posedge clk) begin
            if (rst) cnt_q <= '0;
            else     cnt_q <= cnt_d;
        end

        assign busy[r] = (cnt_q != '0);
    end
endmodule

// File: rtl/simd_pair_rules.sv
module simd_pair_rules
    import simd_pair_pkg::*;
(
    input  logic            s0_vld,
    input  op_t             s0,
    input  logic            s1_vld,
    input  op_t             s1,
    input  logic [NREG-1:0] busy,
    output logic            go_u,
    output logic            go_v
);
    function automatic logic writes_simd(op_t o);
        return o.wr && (o.cls != CLS_EXT);
    endfunction

    function automatic logic blocked(op_t o, logic [NREG-1:0] b);
        if (o.cls == CLS_EXT) return 1'b0;
        return b[o.sa] || b[o.sb] || (o.wr && b[o.dst]);
    endfunction

    logic dep_hit;
    logic unit_clash;
    logic form_clash;

    always_comb begin
        dep_hit = writes_simd(s0) && (s1.cls != CLS_EXT) &&
                  ((s1.sa == s0.dst) || (s1.sb == s0.dst) ||
                   (s1.wr && s1.dst == s0.dst));
        unit_clash = ((s0.cls == CLS_SHF) && (s1.cls == CLS_SHF)) ||
                     ((s0.cls == CLS_MUL) && (s1.cls == CLS_MUL));
        form_clash = s1.mem || (s0.mem && s1.cls == CLS_EXT);
        go_u = s0_vld && !blocked(s0, busy);
        go_v = go_u && s1_vld && !blocked(s1, busy) &&
               !dep_hit && !unit_clash && !form_clash;
    end
endmodule

// File: rtl/simd_pair_issue.sv
module simd_pair_issue
    import simd_pair_pkg::*;
#(
    parameter int MUL_LAT = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            s0_vld,
    input  logic [OP_W-1:0] s0_op,
    input  logic            s1_vld,
    input  logic [OP_W-1:0] s1_op,
    output logic [1:0]      consumed,
    output logic            issue_u,
    output logic            issue_v,
    output logic [OP_W-1:0] u_op,
    output logic [OP_W-1:0] v_op
);
    typedef struct packed {
        logic issue_u;
        logic issue_v;
        op_t  u_op;
        op_t  v_op;
    } stage_t;

    stage_t          st_d, st_q;
    op_t             s0, s1;
    logic            go_u, go_v;
    logic [NREG-1:0] busy;

    assign s0 = op_t'(s0_op);
    assign s1 = op_t'(s1_op);

    simd_pair_rules u_rules (
        .s0_vld (s0_vld),
        .s0     (s0),
        .s1_vld (s1_vld),
        .s1     (s1),
        .busy   (busy),
        .go_u   (go_u),
        .go_v   (go_v)
    );

    simd_pair_scoreboard #(.MUL_LAT(MUL_LAT)) u_sb (
        .clk   (clk),
        .rst   (rst),
        .set_a (go_u && s0.cls == CLS_MUL && s0.wr),
        .idx_a (s0.dst),
        .set_b (go_v && s1.cls == CLS_MUL && s1.wr),
        .idx_b (s1.dst),
        .busy  (busy)
    );

    always_comb begin
        st_d         = st_q;
        st_d.issue_u = go_u;
        st_d.issue_v = go_v;
        if (go_u) st_d.u_op = s0;
        if (go_v) st_d.v_op = s1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign consumed = rst ? 2'd0 : ({1'b0, go_u} + {1'b0, go_v});
    assign issue_u  = st_q.issue_u;
    assign issue_v  = st_q.issue_v;
    assign u_op     = st_q.u_op;
    assign v_op     = st_q.v_op;
endmodule

// File: rtl/simd_pair_issue_chk.sv
module simd_pair_issue_chk
    import simd_pair_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [1:0]      consumed,
    input logic            issue_u,
    input logic            issue_v,
    input logic [OP_W-1:0] u_op,
    input logic [OP_W-1:0] v_op
);
    op_t uo, vo;
    assign uo = op_t'(u_op);
    assign vo = op_t'(v_op);

    AST_V_NEEDS_U: assert property (@(posedge clk) disable iff (rst)
        issue_v |-> issue_u); // R1
    AST_POP_RANGE: assert property (@(posedge clk) disable iff (rst)
        consumed != 2'd3); // R7
    AST_POP_TO_ISSUE: assert property (@(posedge clk) disable iff (rst)
        (consumed != 2'd0) |=> issue_u); // R1
    AST_NO_SHF_PAIR: assert property (@(posedge clk) disable iff (rst)
        issue_v |-> !(uo.cls == CLS_SHF && vo.cls == CLS_SHF)); // R3
    AST_NO_MUL_PAIR: assert property (@(posedge clk) disable iff (rst)
        issue_v |-> !(uo.cls == CLS_MUL && vo.cls == CLS_MUL)); // R4
    AST_V_NO_MEM: assert property (@(posedge clk) disable iff (rst)
        issue_v |-> !vo.mem); // R5
    AST_MEM_NO_EXT: assert property (@(posedge clk) disable iff (rst)
        issue_v && uo.mem |-> vo.cls != CLS_EXT); // R6
    AST_MUL_GAP: assert property (@(posedge clk) disable iff (rst)
        (issue_u && uo.cls == CLS_MUL && uo.wr) |=>
        !(issue_u && uo.cls != CLS_EXT &&
          (uo.sa == $past(uo.dst) || uo.sb == $past(uo.dst) ||
           (uo.wr && uo.dst == $past(uo.dst))))); // R8
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!issue_u && !issue_v)); // R10
endmodule

bind simd_pair_issue simd_pair_issue_chk u_chk (.*);

// File: tb/simd_pair_issue_test.sv
module simd_pair_issue_test;
    import simd_pair_pkg::*;

    localparam time CLK_PERIOD = 10;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            s0_vld = 1'b0, s1_vld = 1'b0;
    logic [OP_W-1:0] s0_op = '0, s1_op = '0;
    logic [1:0]      consumed;
    logic            issue_u, issue_v;
    logic [OP_W-1:0] u_op, v_op;
    int              n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_pair_issue uut (
        .clk(clk), .rst(rst),
        .s0_vld(s0_vld), .s0_op(s0_op),
        .s1_vld(s1_vld), .s1_op(s1_op),
        .consumed(consumed), .issue_u(issue_u), .issue_v(issue_v),
        .u_op(u_op), .v_op(v_op)
    );

    function automatic logic [OP_W-1:0] mk(logic mem, logic wr, logic [1:0] cls,
                                           int d, int a, int b);
        return {mem, wr, cls, 3'(d), 3'(a), 3'(b)};
    endfunction

    task automatic check(logic ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one cycle: drive, check pop count, then check registered outputs
    task automatic step(logic v0, logic [OP_W-1:0] o0, logic v1, logic [OP_W-1:0] o1,
                        int exp, string tag);
        @(negedge clk);
        s0_vld = v0; s0_op = o0; s1_vld = v1; s1_op = o1;
        #1;
        check(consumed == 2'(exp), {tag, " consumed"}, 32'(consumed), 32'(exp));
        @(posedge clk); #1;
        check(issue_u == (exp >= 1), {tag, " issue_u"}, 32'(issue_u), 32'(exp >= 1));
        check(issue_v == (exp == 2), {tag, " issue_v"}, 32'(issue_v), 32'(exp == 2));
        if (exp >= 1) check(u_op == o0, {tag, " u_op"}, 32'(u_op), 32'(o0));
        if (exp == 2) check(v_op == o1, {tag, " v_op"}, 32'(v_op), 32'(o1));
    endtask

    task automatic drain();
        for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b0, '0, 0, "R7 idle");
    endtask

    task automatic t_reset();
        @(negedge clk);
        s0_vld = 1'b1; s0_op = mk(0, 1, 0, 1, 2, 3);
        s1_vld = 1'b1; s1_op = mk(0, 1, 0, 4, 5, 6);
        #1;
        check(consumed == 2'd0, "R10 consumed in reset", 32'(consumed), 0);
        check(!issue_u && !issue_v, "R10 issue in reset", {issue_u, issue_v}, 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_pairs();
        step(1, mk(0,1,0,1,2,3), 1, mk(0,1,0,4,5,6), 2, "R1 alu pair");
        step(1, mk(0,1,0,1,2,3), 1, mk(0,1,0,4,1,6), 1, "R2 raw");
        step(1, mk(0,1,0,1,2,3), 1, mk(0,1,0,1,5,6), 1, "R2 waw");
        step(1, mk(0,1,0,1,2,3), 1, mk(0,1,0,2,5,6), 2, "R2 war ok");
        step(1, mk(0,0,0,1,2,3), 1, mk(0,1,0,4,1,6), 2, "R2 no write");
        step(1, mk(0,1,1,1,2,3), 1, mk(0,1,1,4,5,6), 1, "R3 two shf");
        step(1, mk(0,1,1,1,2,3), 1, mk(0,1,0,4,5,6), 2, "R3 shf+alu");
        step(1, mk(0,1,2,1,2,3), 1, mk(0,1,2,4,5,6), 1, "R4 two mul");
        drain();
        step(1, mk(0,1,0,4,5,6), 1, mk(0,1,2,1,2,3), 2, "R4 alu+mul");
        drain();
        step(1, mk(0,1,0,1,2,3), 1, mk(1,1,0,4,5,6), 1, "R5 mem younger");
        step(1, mk(1,1,0,1,2,3), 1, mk(0,1,0,4,5,6), 2, "R5 mem older");
        step(1, mk(1,1,0,1,2,3), 1, mk(0,1,3,4,5,6), 1, "R6 mem+ext");
        step(1, mk(0,1,0,1,2,3), 1, mk(0,1,3,1,1,1), 2, "R11 ext no hazard");
        step(1, mk(0,1,0,1,2,3), 0, mk(0,1,0,4,5,6), 1, "R7 lone");
        step(0, mk(0,1,0,1,2,3), 1, mk(0,1,0,4,5,6), 0, "R7 empty head");
    endtask

    task automatic t_mul_latency();
        step(1, mk(0,1,2,1,2,3), 0, '0, 1, "R8 mul");
        step(1, mk(0,1,0,4,1,5), 0, '0, 0, "R8 dep c1");
        step(1, mk(0,1,0,4,1,5), 0, '0, 0, "R8 dep c2");
        step(1, mk(0,1,0,4,1,5), 0, '0, 1, "R8 dep c3");
        step(1, mk(0,1,2,2,3,3), 0, '0, 1, "R8 mul2");
        step(1, mk(0,1,0,2,4,5), 0, '0, 0, "R8 waw busy");
        step(1, mk(0,1,0,6,4,5), 1, mk(0,1,0,7,4,5), 2, "R8 indep overlap");
        drain();
        step(1, mk(0,1,2,3,1,1), 0, '0, 1, "R9 mul");
        step(1, mk(0,1,0,4,5,6), 1, mk(0,1,0,7,3,6), 1, "R9 younger busy");
        drain();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_pairs();
        t_mul_latency();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule